// File: doc/BRIEF.md
# Serial Amplifier Control Register

This block is the digital control front end of a mixing audio amplifier. An external host writes one 8-bit command at a time over a write-only three-wire serial link: a serial data line, a serial clock and an active-high frame enable. The three lines pass through two-flop synchronizers into the faster system clock. Edges of the serial clock and of the frame enable are detected in that clock domain.

A completed frame is committed when the enable falls. The command has a 3-bit output mode and a 5-bit volume code. The mode is decoded into an enable and source selects for a speaker output and for a headset pair. The volume code is presented as a signed gain in half-dB units.

Leaving full standby starts a bias-settling timer. The output enables stay low until that timer reports ready.

Top module: `amp_ctl_top`

## Requirements
- R1: A frame is shifted in least significant bit first, one bit per rising serial clock edge seen while the enable is high. After commit, mode_q holds frame bits 2..0 and vol_q holds bits 7..3, with bit 7 as the volume MSB.
- R2: The frame is committed only on the enable's high-to-low transition, and only if at least 8 bits were captured. A frame of fewer bits leaves mode_q and vol_q unchanged.
- R3: Only the first 8 bits of a longer frame are kept; later clock and data activity in that frame has no effect on the committed value.
- R4: A rising enable restarts the bit count. Serial clock pulses while the enable is low shift nothing.
- R5: After reset, mode_q is 0, vol_q is 27, gain_hdb is +12 (that is, +6 dB), and ready is low.
- R6: gain_hdb equals 3*vol_q - 69, so code 0 gives -69 (-34.5 dB) and code 31 gives +24 (+12 dB).
- R7: In mode 0 the speaker and headset enables, all their source selects, and ready are low.
- R8: Speaker routing by mode, where the phone select means the phone input at +6 dB and the line select means the volume-scaled R+L sum. Mode 1 is phone only, mode 3 is line only, mode 5 is both, and mode 7 is phone only. Modes 2, 4 and 6 are off.
- R9: Headset routing by mode, where the phone select means the phone input at 0 dB and the line select means the volume-scaled R and L. Mode 2 is phone only, mode 4 is line only, and modes 6 and 7 are both. Modes 1, 3 and 5 are off.
- R10: When a commit moves the mode from 0 to non-zero, ready rises exactly WAKE_CYCLES system clocks after the commit. spk_en and hs_en stay low until then, and afterwards equal the decoded routing.
- R11: A commit to mode 0 clears ready in the same cycle the mode changes, even while the timer is still running. A commit between two non-zero modes leaves ready as it was.
- R12: Without a commit, mode_q and vol_q hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_en | input | 1 | Frame enable, active high (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| mode_q | output | 3 | Committed output mode |
| vol_q | output | 5 | Committed volume code |
| gain_hdb | output | 8 | Signed line gain in half-dB |
| ready | output | 1 | Bias settled after leaving standby |
| spk_en | output | 1 | Speaker amplifier enable |
| spk_phone | output | 1 | Speaker takes phone input (+6 dB) |
| spk_line | output | 1 | Speaker takes scaled R+L |
| hs_en | output | 1 | Headset amplifier enable |
| hs_phone | output | 1 | Headset takes phone input (0 dB) |
| hs_line | output | 1 | Headset takes scaled R and L |

## Verification
Random full frames with random mode and volume check every field position, the gain map and both routing tables. They also cover random transitions into and out of standby. Directed frames cover the cases random ones rarely hit:
- Short frames show that an incomplete frame cannot commit.
- Over-long frames with inverted tail bits show that the ninth and later bits are dropped.
- Clock pulses with the enable low, followed by an aborted frame, show the bit count restarting on the enable's rising edge.
- A measured wake from standby separates an exact delay from an off-by-one.
- A return to standby during the wake shows the cancellation.

// File: rtl/amp_ctl_pkg.sv
// Package: shared widths, command field layout and routing type for the
// serial amplifier control block. Assumes an 8-bit command, mode in the low
// three bits.
package amp_ctl_pkg;
    localparam int FRAME_BITS = 8;
    localparam int MODE_W     = 3;
    localparam int VOL_W      = 5;
    localparam int GAIN_W     = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int GAIN_STEP  = 3;   // half-dB per volume code
    localparam int GAIN_FLOOR = 69;  // half-dB below zero at code 0

    typedef struct packed {
        logic on;
        logic phone;
        logic line;
    } route_t;

    typedef struct packed {
        logic [VOL_W-1:0]  vol;
        logic [MODE_W-1:0] mode;
    } cmd_t;
endpackage

// File: rtl/amp_ser_sync.sv
// Brings the three asynchronous serial lines into the system clock with
// two-flop synchronizers and produces one-cycle edge pulses for the serial
// clock and the enable. Assumes each serial level lasts several system clocks.
module amp_ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_en,
    input  logic ser_dat,
    output logic sclk_rise,
    output logic en_rise,
    output logic en_fall,
    output logic en_lvl,
    output logic dat_lvl
);
    logic [2:0] stage [STAGES];
    logic [1:0] prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: one synchronizer rank for all three lines.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[i] <= '0;
                else if (i == 0)
                    stage[i] <= {ser_clk, ser_en, ser_dat};
                else
                    stage[i] <= stage[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Purpose: remember last synchronized clock/enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= '0;
        else
            prev <= stage[STAGES-1][2:1];
    end

    always_comb begin
        sclk_rise = stage[STAGES-1][2] & ~prev[1];
        en_rise   = stage[STAGES-1][1] & ~prev[0];
        en_fall   = ~stage[STAGES-1][1] & prev[0];
        en_lvl    = stage[STAGES-1][1];
        dat_lvl   = stage[STAGES-1][0];
    end
endmodule

// File: rtl/amp_frame_rx.sv
// Shift register and bit counter for one serial command. Bits enter LSB
// first; bits past the frame length are dropped; a commit pulse is issued
// on enable fall only when a full frame was captured.
module amp_frame_rx
    import amp_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  en_rise,
    input  logic                  en_fall,
    input  logic                  en_lvl,
    input  logic                  dat_lvl,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] frame
);
    logic [CNT_W-1:0] nbits;
    logic             full;

    assign full = (nbits == CNT_W'(FRAME_BITS));

    // Purpose: count captured bits, restart at each enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nbits <= '0;
        else if (en_rise)
            nbits <= '0;
        else if (sclk_rise && en_lvl && !full)
            nbits <= nbits + 1'b1;
    end

    // Purpose: shift in data LSB first until the frame is full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (sclk_rise && en_lvl && !full && !en_rise)
            frame <= {dat_lvl, frame[FRAME_BITS-1:1]};
    end

    assign commit = en_fall & full;
endmodule

// File: rtl/amp_route_dec.sv
// Decodes the output mode into speaker and headset routing. Enables are
// gated by the bias-ready flag; source selects follow the mode alone.
module amp_route_dec
    import amp_ctl_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              ready,
    output route_t            spk,
    output route_t            hs
);
    // Purpose: routing table for both outputs.
    always_comb begin
        spk = '0;
        hs  = '0;
        unique case (mode)
            3'd1: spk = '{on: 1'b1, phone: 1'b1, line: 1'b0};
            3'd2: hs  = '{on: 1'b1, phone: 1'b1, line: 1'b0};
            3'd3: spk = '{on: 1'b1, phone: 1'b0, line: 1'b1};
            3'd4: hs  = '{on: 1'b1, phone: 1'b0, line: 1'b1};
            3'd5: spk = '{on: 1'b1, phone: 1'b1, line: 1'b1};
            3'd6: hs  = '{on: 1'b1, phone: 1'b1, line: 1'b1};
            3'd7: begin
                spk = '{on: 1'b1, phone: 1'b1, line: 1'b0};
                hs  = '{on: 1'b1, phone: 1'b1, line: 1'b1};
            end
            default: ;
        endcase
        spk.on = spk.on & ready;
        hs.on  = hs.on & ready;
    end
endmodule

// File: rtl/amp_wake_timer.sv
// Bias-settling timer. Started by a commit leaving standby, cancelled by a
// commit into standby. Ready rises WAKE_CYCLES clocks after the start.
module amp_wake_timer #(
    parameter int WAKE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic ready
);
    localparam int TW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);

    logic [TW-1:0] cnt;
    logic          run;

    // Purpose: count settling time and raise ready at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            run   <= 1'b0;
            ready <= 1'b0;
        end else if (cancel) begin
            cnt   <= '0;
            run   <= 1'b0;
            ready <= 1'b0;
        end else if (start) begin
            cnt   <= '0;
            run   <= 1'b1;
            ready <= 1'b0;
        end else if (run) begin
            if (cnt == TW'(WAKE_CYCLES - 1)) begin
                run   <= 1'b0;
                ready <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/amp_ctl_top.sv
// Top of the serial amplifier control block: synchronizer, frame receiver,
// command register, gain map, routing decoder and wake timer. Assumes the
// system clock is several times faster than the serial clock.
module amp_ctl_top
    import amp_ctl_pkg::*;
#(
    parameter int WAKE_CYCLES = 1000,
    parameter int RESET_VOL   = 27
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_en,
    input  logic                     ser_dat,
    output logic [MODE_W-1:0]        mode_q,
    output logic [VOL_W-1:0]         vol_q,
    output logic signed [GAIN_W-1:0] gain_hdb,
    output logic                     ready,
    output logic                     spk_en,
    output logic                     spk_phone,
    output logic                     spk_line,
    output logic                     hs_en,
    output logic                     hs_phone,
    output logic                     hs_line
);
    logic sclk_rise, en_rise, en_fall, en_lvl, dat_lvl;
    logic commit;
    logic [FRAME_BITS-1:0] frame;
    cmd_t cmd;
    route_t spk, hs;
    logic wake_start, wake_cancel;

    amp_ser_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_dat(ser_dat),
        .sclk_rise(sclk_rise), .en_rise(en_rise), .en_fall(en_fall),
        .en_lvl(en_lvl), .dat_lvl(dat_lvl)
    );

    amp_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .en_rise(en_rise), .en_fall(en_fall),
        .en_lvl(en_lvl), .dat_lvl(dat_lvl),
        .commit(commit), .frame(frame)
    );

    assign cmd = cmd_t'(frame);

    // Purpose: command register loaded on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            vol_q  <= VOL_W'(RESET_VOL);
        end else if (commit) begin
            mode_q <= cmd.mode;
            vol_q  <= cmd.vol;
        end
    end

    assign wake_start  = commit && (mode_q == '0) && (cmd.mode != '0);
    assign wake_cancel = commit && (cmd.mode == '0);

    amp_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n),
        .start(wake_start), .cancel(wake_cancel), .ready(ready)
    );

    // Purpose: volume code to signed half-dB gain.
    always_comb begin
        gain_hdb = $signed(GAIN_W'(GAIN_W'(vol_q) * GAIN_W'(GAIN_STEP))
                           - GAIN_W'(GAIN_FLOOR));
    end

    amp_route_dec u_dec (
        .mode(mode_q), .ready(ready), .spk(spk), .hs(hs)
    );

    assign spk_en    = spk.on;
    assign spk_phone = spk.phone;
    assign spk_line  = spk.line;
    assign hs_en     = hs.on;
    assign hs_phone  = hs.phone;
    assign hs_line   = hs.line;
endmodule

// File: rtl/amp_ctl_checker.sv
// Property checker for amp_ctl_top, attached by bind. Observes ports and the
// internal commit pulse.
module amp_ctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       commit,
    input logic [2:0] mode_q,
    input logic [4:0] vol_q,
    input logic       ready,
    input logic       spk_en,
    input logic       hs_en,
    input logic       spk_phone,
    input logic       spk_line,
    input logic       hs_phone,
    input logic       hs_line
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == 3'd0 |-> !ready && !spk_en && !hs_en && !spk_phone && !spk_line && !hs_phone && !hs_line); // R7
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !spk_en && !hs_en); // R10
    AST_READY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> mode_q != 3'd0); // R11
    AST_SPK_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        spk_en |-> mode_q[0]); // R8
    AST_HS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (mode_q == 3'd2 || mode_q >= 3'd4) && mode_q != 3'd5); // R9
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({mode_q, vol_q})); // R12
endmodule

bind amp_ctl_top amp_ctl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .mode_q(mode_q), .vol_q(vol_q), .ready(ready),
    .spk_en(spk_en), .hs_en(hs_en),
    .spk_phone(spk_phone), .spk_line(spk_line),
    .hs_phone(hs_phone), .hs_line(hs_line)
);

// File: tb/amp_ctl_top_test.sv
module amp_ctl_top_test;
    localparam int W = 20;
    localparam int HALF = 4;

    logic clk = 0, rst_n = 0;
    logic ser_clk = 0, ser_en = 0, ser_dat = 0;
    logic [2:0] mode_q;
    logic [4:0] vol_q;
    logic signed [7:0] gain_hdb;
    logic ready, spk_en, spk_phone, spk_line, hs_en, hs_phone, hs_line;

    int checks = 0, errors = 0, cyc = 0;
    logic [2:0] em = 0;
    logic [4:0] ev = 27;

    always #5 clk = ~clk;

    amp_ctl_top #(.WAKE_CYCLES(W), .RESET_VOL(27)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_dat(ser_dat), .mode_q(mode_q), .vol_q(vol_q), .gain_hdb(gain_hdb),
        .ready(ready), .spk_en(spk_en), .spk_phone(spk_phone),
        .spk_line(spk_line), .hs_en(hs_en), .hs_phone(hs_phone), .hs_line(hs_line)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Routing model: {on, phone, line}
    function automatic logic [2:0] spk_model(input logic [2:0] m);
        case (m)
            3'd1, 3'd7: return 3'b110;
            3'd3:       return 3'b101;
            3'd5:       return 3'b111;
            default:    return 3'b000;
        endcase
    endfunction
    function automatic logic [2:0] hs_model(input logic [2:0] m);
        case (m)
            3'd2:       return 3'b110;
            3'd4:       return 3'b101;
            3'd6, 3'd7: return 3'b111;
            default:    return 3'b000;
        endcase
    endfunction

    // Sends n bits of pattern p LSB first, optionally without closing.
    task automatic send(input logic [15:0] p, input int n, input bit close);
        ser_en = 1; wt(HALF);
        for (int i = 0; i < n; i++) begin
            ser_dat = p[i]; wt(HALF);
            ser_clk = 1; wt(HALF);
            ser_clk = 0;
        end
        wt(HALF);
        if (close) begin ser_en = 0; wt(8); end
    endtask

    task automatic check_regs(input string req);
        chk(req, mode_q, em);
        chk(req, vol_q, ev);
    endtask

    task automatic check_all();
        logic [2:0] s, h;
        s = spk_model(em); h = hs_model(em);
        check_regs("R1");
        chk("R6", gain_hdb, 3 * ev - 69);
        chk("R8", {spk_phone, spk_line}, s[1:0]);
        chk("R9", {hs_phone, hs_line}, h[1:0]);
    endtask

    // Full frame: commit, then after wake window check enables.
    task automatic frame8(input logic [7:0] b);
        send({8'h00, b}, 8, 1);
        em = b[2:0]; ev = b[7:3];
        check_all();
        wt(W + 4);
        chk("R10", ready, em != 0);
        chk("R10", spk_en, spk_model(em) >> 2);
        chk("R10", hs_en, hs_model(em) >> 2);
        if (em == 0) chk("R7", {ready, spk_en, hs_en, spk_phone, spk_line, hs_phone, hs_line}, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected 0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        logic [7:0] b;
        void'($urandom(32'd7741));
        wt(3); rst_n = 1; wt(1);
        // R5 reset state
        chk("R5", mode_q, 0); chk("R5", vol_q, 27);
        chk("R5", gain_hdb, 12); chk("R5", ready, 0);
        chk("R7", {spk_en, hs_en}, 0);

        // R6 boundaries
        frame8(8'b11111_011); chk("R6", gain_hdb, 24);
        frame8(8'b00000_000); chk("R6", gain_hdb, -69);

        // R10 exact wake time
        send(16'h00A5, 8, 0);
        ser_en = 0;
        while (mode_q != 3'd5) @(negedge clk);
        em = 5; ev = 5'b10100;
        k = 0;
        while (!ready && k < W + 10) begin chk("R10", spk_en, 0); @(negedge clk); k++; end
        chk("R10", k, W);
        chk("R10", {spk_en, spk_phone, spk_line}, 3'b111);
        // R11 mode change between non-zero modes keeps ready
        frame8(8'b01010_110); chk("R11", ready, 1);
        // R11 cancel during wake
        frame8(8'b01010_000);
        send(16'h0003, 8, 0); ser_en = 0;
        wt(5 + W / 2); chk("R11", ready, 0);
        send(16'h0000, 8, 0); ser_en = 0;
        while (mode_q != 3'd0) @(negedge clk);
        chk("R11", ready, 0);
        em = 0; ev = 0;
        wt(W + 4); chk("R11", ready, 0);

        // R2 short frame ignored
        frame8(8'b10001_100);
        send(16'h00FF, 7, 1);
        check_regs("R2");
        send(16'h0000, 0, 1);
        check_regs("R2");
        // R3 long frame: tail inverted
        send(16'hFF3A, 16, 1);
        em = 3'b010; ev = 5'b00111; check_regs("R3");
        // R4 clock pulses with enable low ignored, aborted frame restarted
        for (int i = 0; i < 5; i++) begin
            ser_dat = 1; wt(HALF); ser_clk = 1; wt(HALF); ser_clk = 0;
        end
        send(16'h0011, 4, 0); ser_en = 0; wt(HALF);
        check_regs("R4");
        send(16'h0000, 3, 0); ser_en = 0; wt(HALF);
        frame8(8'b01100_001);
        check_regs("R4");
        // R12 idle hold
        wt(50); check_regs("R12");

        // Random frames, all modes
        for (int i = 0; i < 40; i++) begin
            b = 8'($urandom);
            frame8(b);
        end
        for (int m = 0; m < 8; m++) frame8({5'($urandom), 3'(m)});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule